// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit maps large, naturally aligned regions of the effective address space straight onto physical memory. It bypasses any page walk. It holds a small set of translation entries. Each entry is a pair of 32-bit words that software loads through a plain write port. For every request the unit compares the effective address against all entries at once. The compare width of each entry is narrowed by its own thermometer-coded length field, so one entry can cover anything from 128 KB up to 256 MB.

On a hit the unit builds the physical address and returns the winning entry's cache attributes: write-through, inhibited, coherent and guarded. It also judges the access against the entry's protection code for the requested kind of access. Each entry carries separate enables for supervisor and user mode. All results are registered and appear on the cycle after the request. A miss only reports that nothing matched. Any fallback translation is left to the surrounding logic.

Top module: `blk_xlate_match`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all `rsp_*` outputs are zero. After reset every entry is disabled, so a request misses until an entry has been written.
- R2: A cycle with `wr_en` high and `wr_upper` high loads the tag word of entry `wr_sel`. The tag word places the block index in bits 31:17, the length field in bits 12:2, the supervisor enable in bit 1 and the user enable in bit 0. Other bits are ignored.
- R3: A cycle with `wr_en` high and `wr_upper` low loads the data word of entry `wr_sel`. The data word places the physical block index in bits 31:17, W/I/M/G in bits 6/5/4/3 and the protection code in bits 1:0. `rsp_attr` reports them as {W,I,M,G}.
- R4: An entry matches when `req_ea[31:17]`, with the bits set in the length field cleared, equals the block index with the same bits cleared. The length field is thermometer coded: zero means 128 KB, and each further low one doubles the block, up to 0x7FF for 256 MB.
- R5: A matching entry only counts as a hit when its enable for the requested mode is set. `req_user` high selects the user enable, and low selects the supervisor enable.
- R6: On a hit, `rsp_pa[31:17]` is the physical block index OR-ed with the effective-address index bits under the length field. `rsp_pa[16:0]` equals `req_ea[16:0]`.
- R7: When several entries hit, the lowest-numbered one supplies the result, and `rsp_entry` gives its number.
- R8: Protection code 0 faults every access, codes 1 and 3 fault a write (`req_write` high), and code 2 never faults.
- R9: An instruction fetch (`req_fetch` high) that hits an entry with G set raises `rsp_fault`.
- R10: `rsp_valid` is high exactly on the cycle after a cycle with `req_valid` high.
- R11: A miss gives `rsp_hit`, `rsp_fault`, `rsp_entry`, `rsp_attr` and `rsp_pa` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one entry word this cycle |
| wr_sel | input | SEL_W | Entry number to load |
| wr_upper | input | 1 | 1 = tag word, 0 = data word |
| wr_data | input | 32 | Word to load |
| req_valid | input | 1 | Translation request |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Result is present |
| rsp_hit | output | 1 | An entry matched |
| rsp_fault | output | 1 | Protection violation on the hit |
| rsp_entry | output | SEL_W | Number of the winning entry |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 4 | {W,I,M,G} of the winning entry |

## Verification
The bench builds the unit with its default of four entries, so `wr_sel` and `rsp_entry` are two bits wide. With four entries the test can stack overlapping blocks in every priority position and give each entry a different length. The random phase draws lengths across all twelve thermometer values, 128 KB to 256 MB. It aims most addresses inside a programmed block, with random bits under the length field, which exercises the merge of the physical address at every width.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int WORD_W = 32;
  localparam int EA_W   = 32;
  localparam int BIDX_W = 15;
  localparam int LEN_W  = 11;
  localparam int OFS_W  = EA_W - BIDX_W;
  localparam int ATTR_W = 4;

  // tag word, decoded
  typedef struct packed {
    logic [BIDX_W-1:0] eidx;
    logic [LEN_W-1:0]  len;
    logic              sv;
    logic              uv;
  } ent_hi_t;

  // data word, decoded
  typedef struct packed {
    logic [BIDX_W-1:0] ridx;
    logic              w;
    logic              i;
    logic              m;
    logic              g;
    logic [1:0]        pp;
  } ent_lo_t;

  function automatic ent_hi_t unpack_hi(input logic [WORD_W-1:0] d);
    ent_hi_t h;
    h.eidx = d[WORD_W-1 -: BIDX_W];
    h.len  = d[LEN_W+1:2];
    h.sv   = d[1];
    h.uv   = d[0];
    return h;
  endfunction

  function automatic ent_lo_t unpack_lo(input logic [WORD_W-1:0] d);
    ent_lo_t l;
    l.ridx = d[WORD_W-1 -: BIDX_W];
    l.w    = d[6];
    l.i    = d[5];
    l.m    = d[4];
    l.g    = d[3];
    l.pp   = d[1:0];
    return l;
  endfunction
endpackage

// File: rtl/blkx_regfile.sv
module blkx_regfile
  import blkx_pkg::*;
#(
  parameter  int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_sel,
  input  logic              wr_upper,
  input  logic [WORD_W-1:0] wr_data,
  output ent_hi_t           hi_q [N],
  output ent_lo_t           lo_q [N]
);
  // bits of the words that carry no field
  logic unused_bits;
  assign unused_bits = ^{wr_data[OFS_W-1:LEN_W+2], wr_data[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        hi_q[k] <= '0;
        lo_q[k] <= '0;
      end
    end else if (wr_en) begin
      if (wr_upper) hi_q[wr_sel] <= unpack_hi(wr_data);
      else          lo_q[wr_sel] <= unpack_lo(wr_data);
    end
  end
endmodule

// File: rtl/blkx_entry_cmp.sv
module blkx_entry_cmp
  import blkx_pkg::*;
(
  input  ent_hi_t           hi,
  input  logic [BIDX_W-1:0] ridx,
  input  logic [EA_W-1:0]   ea,
  input  logic              user,
  output logic              hit,
  output logic [BIDX_W-1:0] pa_idx
);
  logic [BIDX_W-1:0] ea_idx;
  logic [BIDX_W-1:0] span;
  logic              tag_eq;
  logic              mode_ok;
  logic [OFS_W-1:0]  unused_ofs;

  assign ea_idx     = ea[EA_W-1 -: BIDX_W];
  assign unused_ofs = ea[OFS_W-1:0];
  assign span       = {{(BIDX_W-LEN_W){1'b0}}, hi.len};
  assign tag_eq     = (ea_idx & ~span) == (hi.eidx & ~span);
  assign mode_ok    = user ? hi.uv : hi.sv;
  assign hit        = tag_eq && mode_ok;
  assign pa_idx     = ridx | (ea_idx & span);
endmodule

// File: rtl/blkx_prio_sel.sv
module blkx_prio_sel #(
  parameter  int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  hit_vec,
  output logic          any,
  output logic [SW-1:0] idx
);
  always_comb begin
    any = |hit_vec;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_vec[k]) idx = SW'(k);
    end
  end
endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
  import blkx_pkg::*;
#(
  parameter  int NUM_ENT = 4,
  localparam int SEL_W   = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_upper,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              req_user,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [SEL_W-1:0]  rsp_entry,
  output logic [EA_W-1:0]   rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr
);
  ent_hi_t           hi_q   [NUM_ENT];
  ent_lo_t           lo_q   [NUM_ENT];
  logic [NUM_ENT-1:0] hit_vec;
  logic [BIDX_W-1:0] pa_idx [NUM_ENT];
  logic              any_hit;
  logic [SEL_W-1:0]  win;
  ent_lo_t           win_lo;
  logic              prot_bad;
  logic              guard_bad;

  blkx_regfile #(.N(NUM_ENT)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_upper (wr_upper),
    .wr_data  (wr_data),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    blkx_entry_cmp u_cmp (
      .hi     (hi_q[e]),
      .ridx   (lo_q[e].ridx),
      .ea     (req_ea),
      .user   (req_user),
      .hit    (hit_vec[e]),
      .pa_idx (pa_idx[e])
    );
  end

  blkx_prio_sel #(.N(NUM_ENT)) u_prio (
    .hit_vec (hit_vec),
    .any     (any_hit),
    .idx     (win)
  );

  assign win_lo    = lo_q[win];
  // code 0: nothing allowed; odd codes: read only; code 2: read/write
  assign prot_bad  = (win_lo.pp == 2'd0) || (win_lo.pp[0] && req_write);
  assign guard_bad = req_fetch && win_lo.g;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_entry <= '0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid && any_hit) begin
        rsp_hit   <= 1'b1;
        rsp_fault <= prot_bad || guard_bad;
        rsp_entry <= win;
        rsp_pa    <= {pa_idx[win], req_ea[OFS_W-1:0]};
        rsp_attr  <= {win_lo.w, win_lo.i, win_lo.m, win_lo.g};
      end else begin
        rsp_hit   <= 1'b0;
        rsp_fault <= 1'b0;
        rsp_entry <= '0;
        rsp_pa    <= '0;
        rsp_attr  <= '0;
      end
    end
  end
endmodule

// File: rtl/blkx_chk.sv
module blkx_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic [31:0] rsp_pa,
  input logic [3:0]  rsp_attr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit && !rsp_fault && rsp_pa == '0));

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_hit));

  // R8
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_hit);

  // R11
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_attr == '0 && !rsp_fault));

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_hit || rsp_pa[16:0] == $past(req_ea[16:0])));
endmodule

bind blk_xlate_match blkx_chk u_chk (.*);

// File: tb/test_blk_xlate_match.sv
`timescale 1ns/1ps
module test_blk_xlate_match;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        wr_upper = 1'b0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic        req_user = 1'b0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [1:0]  rsp_entry;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_attr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] m_hi [4];
  logic [31:0] m_lo [4];

  always #10 clk = ~clk;

  blk_xlate_match i_blk_xlate_match (.*);

  function automatic logic [31:0] mk_hi(input logic [14:0] ei, input logic [10:0] len,
                                        input logic sv, input logic uv);
    return {ei, 4'b0, len, sv, uv};
  endfunction

  function automatic logic [31:0] mk_lo(input logic [14:0] ri, input logic [3:0] wimg,
                                        input logic [1:0] pp);
    return {ri, 10'b0, wimg, 1'b0, pp};
  endfunction

  // expected {hit, fault, entry, attr, pa}
  function automatic logic [39:0] model(input logic [31:0] ea, input logic user,
                                        input logic wr, input logic fe);
    for (int k = 0; k < 4; k++) begin
      logic [14:0] ei, len15, idx, ri;
      logic en, g, f;
      logic [1:0] pp;
      ei = m_hi[k][31:17]; len15 = {4'b0, m_hi[k][12:2]};
      en = user ? m_hi[k][0] : m_hi[k][1];
      idx = ea[31:17];
      ri = m_lo[k][31:17]; g = m_lo[k][3]; pp = m_lo[k][1:0];
      if (en && ((idx & ~len15) == (ei & ~len15))) begin
        f = (pp == 2'd0) || ((pp == 2'd1 || pp == 2'd3) && wr) || (fe && g);
        return {1'b1, f, 2'(k), m_lo[k][6:3], ri | (idx & len15), ea[16:0]};
      end
    end
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input int sel, input bit upper, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_upper = upper; wr_data = d;
    if (upper) m_hi[sel] = d; else m_lo[sel] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input int sel, input logic [31:0] hi, input logic [31:0] lo);
    wr_word(sel, 1'b1, hi);
    wr_word(sel, 1'b0, lo);
  endtask

  task automatic req(input logic [31:0] ea, input logic user, input logic wr,
                     input logic fe, input string tag);
    logic [39:0] e, a;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_user = user; req_write = wr; req_fetch = fe;
    @(negedge clk);
    req_valid = 1'b0;
    e = model(ea, user, wr, fe);
    a = {rsp_hit, rsp_fault, rsp_entry, rsp_attr, rsp_pa};
    check(rsp_valid === 1'b1 && a === e, tag, {24'b0, rsp_valid, a}, {24'b0, 1'b1, e});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    for (int k = 0; k < 4; k++) begin m_hi[k] = '0; m_lo[k] = '0; end
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check({rsp_valid, rsp_hit, rsp_fault, rsp_pa} === '0, "R1 reset outputs",
          64'({rsp_valid, rsp_hit, rsp_fault, rsp_pa}), 64'd0);
    rst = 1'b0;
    // R1 R11: no entry enabled after reset
    req(32'h0000_0000, 1'b0, 1'b0, 1'b0, "R1 R11 miss after reset");
    check(rsp_hit === 1'b0, "R1 no hit", 64'(rsp_hit), 64'd0);

    // R2 R3 R6: 128 KB block, unused bits set in both words
    prog(0, mk_hi(15'h0001, 11'h000, 1'b1, 1'b1) | 32'h0001_E000,
            mk_lo(15'h0100, 4'b1010, 2'd2) | 32'h0001_FF84);
    req(32'h0003_2345, 1'b0, 1'b1, 1'b0, "R2 R3 R6 basic hit");
    check(rsp_pa === 32'h0201_2345 && rsp_attr === 4'b1010, "R6 hand pa/attr",
          64'({rsp_attr, rsp_pa}), 64'({4'b1010, 32'h0201_2345}));
    // R10: idle cycle gives no response
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 idle", 64'(rsp_valid), 64'd0);
    req(32'h0005_2345, 1'b0, 1'b0, 1'b0, "R4 R11 just outside 128K");

    // R4: 256 MB block
    prog(1, mk_hi(15'h0400, 11'h7FF, 1'b1, 1'b1), mk_lo(15'h0000, 4'b0100, 2'd2));
    req(32'h0FFF_FFF0, 1'b0, 1'b0, 1'b0, "R4 256M top");
    check(rsp_pa === 32'h0FFF_FFF0 && rsp_entry === 2'd1, "R4 hand 256M",
          64'({rsp_entry, rsp_pa}), 64'({2'd1, 32'h0FFF_FFF0}));
    req(32'h1000_0000, 1'b0, 1'b0, 1'b0, "R4 256M edge miss");

    // R5: supervisor-only entry
    prog(2, mk_hi(15'h2000, 11'h00F, 1'b1, 1'b0), mk_lo(15'h3000, 4'b0000, 2'd2));
    req(32'h4001_0000, 1'b1, 1'b0, 1'b0, "R5 user blocked");
    check(rsp_hit === 1'b0, "R5 user miss", 64'(rsp_hit), 64'd0);
    req(32'h4001_0000, 1'b0, 1'b0, 1'b0, "R5 supervisor hits");
    // R5: user-only entry
    prog(2, mk_hi(15'h2000, 11'h00F, 1'b0, 1'b1), mk_lo(15'h3000, 4'b0000, 2'd2));
    req(32'h4001_0000, 1'b0, 1'b0, 1'b0, "R5 supervisor blocked");
    req(32'h4001_0000, 1'b1, 1'b0, 1'b0, "R5 user hits");

    // R7: entry 3 overlaps entry 1, entry 1 wins
    prog(3, mk_hi(15'h0400, 11'h003, 1'b1, 1'b1), mk_lo(15'h7000, 4'b0001, 2'd2));
    req(32'h0801_0000, 1'b0, 1'b0, 1'b0, "R7 lowest wins");
    check(rsp_entry === 2'd1, "R7 entry", 64'(rsp_entry), 64'd1);

    // R8: protection codes on entry 2
    for (int pp = 0; pp < 4; pp++) begin
      prog(2, mk_hi(15'h2000, 11'h00F, 1'b1, 1'b1), mk_lo(15'h3000, 4'b0000, 2'(pp)));
      req(32'h4000_1000, 1'b0, 1'b0, 1'b0, "R8 read");
      req(32'h4000_1000, 1'b0, 1'b1, 1'b0, "R8 write");
    end
    prog(2, mk_hi(15'h2000, 11'h00F, 1'b1, 1'b1), mk_lo(15'h3000, 4'b0000, 2'd1));
    req(32'h4000_1000, 1'b0, 1'b1, 1'b0, "R8 ro write");
    check(rsp_fault === 1'b1, "R8 ro write fault", 64'(rsp_fault), 64'd1);

    // R9: guarded fetch
    prog(2, mk_hi(15'h2000, 11'h00F, 1'b1, 1'b1), mk_lo(15'h3000, 4'b0001, 2'd2));
    req(32'h4000_1000, 1'b0, 1'b0, 1'b1, "R9 guarded fetch");
    check(rsp_fault === 1'b1, "R9 fault", 64'(rsp_fault), 64'd1);
    req(32'h4000_1000, 1'b0, 1'b0, 1'b0, "R9 guarded load ok");

    // random mix: R4 R6 R7 R8 R9
    for (int it = 0; it < 600; it++) begin
      logic [31:0] ea;
      int k;
      if ($urandom % 4 == 0) begin
        logic [10:0] len;
        len = 11'((32'd1 << ($urandom % 12)) - 1);
        prog($urandom % 4,
             mk_hi(15'($urandom), len, 1'($urandom), 1'($urandom)),
             mk_lo(15'($urandom), 4'($urandom), 2'($urandom)));
      end
      k = $urandom % 4;
      ea = $urandom;
      if ($urandom % 4 != 0)
        ea[31:17] = m_hi[k][31:17] | (15'($urandom) & {4'b0, m_hi[k][12:2]});
      req(ea, 1'($urandom), 1'($urandom), 1'($urandom), "R4 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule